// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel NOR flash while the flash carries out an embedded program or erase. After a start pulse it reads the device's 8-bit status byte at one polling address again and again. It decides from each byte whether the operation has finished, has failed, or is still running. On every failure, and on success in one of the two polling modes, it writes a single command that returns the flash to array-read mode. It then reports the result as a one-cycle done pulse together with pass, fail and a failure cause.

Two polling conventions are supported, chosen by a 2-bit mode input:
- **Data-match mode:** completion is signalled when bit 7 of the status byte equals bit 7 of the word that was written.
- **Flag mode:** completion is signalled when bit 7 reads 1.

Two error flags can end polling early: bit 5 (pulse limit exceeded) and bit 3 (programming voltage too low). Because bit 7 may settle in the same read that shows an error flag, a flagged read is always followed by one more read before a failure is declared. A read-count limit bounds the whole wait.

The system must supply a polling address that lies in the sector being erased (sector erase) or in any unprotected sector (chip erase).

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `pass_o`, `fail_o` and `bus_req_o` are 0 and `cause_o` is 0.
- R2: A `start_i` pulse while idle latches the mode, polling address, expected bit 7 and read limit. Every status read is a bus read (`bus_we_o`=0) at the latched polling address.
- R3: A bus request stays asserted with stable address, direction and write data until `bus_ack_i`. Read data is evaluated only after the acknowledge.
- R4: In mode 00 a read whose bit 7 equals `exp_d7_i` ends polling with a pass, and no bus write is issued.
- R5: In mode 01 a read with bit 7 = 1 ends polling with a pass, after one exit write has been issued.
- R6: A non-completing read with bit 5 = 1 triggers exactly one further read. If that read completes (per mode), the outcome is a pass; otherwise it is a fail with `cause_o` = 1.
- R7: A non-completing read with bit 3 = 1 and bit 5 = 0 is handled the same way, with `cause_o` = 2. Bit 5 takes priority when both flags are set. A completing read ignores both flags.
- R8: Every fail issues exactly one bus write of data `EXIT_DATA` (default 8'hF0) to `EXIT_ADDR` (default 16'h0555) before `done_o`.
- R9: If `max_reads_i` consecutive reads show neither completion nor a flag, the outcome is a fail with `cause_o` = 3 after exactly that many reads. A limit of 0 acts as 1.
- R10: `done_o` is a one-cycle pulse. At most one of `pass_o` and `fail_o` is set. Both hold until the next accepted start. `start_i` while busy is ignored.
- R11: Modes 10 and 11 behave as mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted while idle) |
| mode_i | input | 2 | Polling mode, 01 = flag mode, others = data-match |
| poll_addr_i | input | AW | Valid polling address |
| exp_d7_i | input | 1 | Bit 7 of the word being programmed |
| max_reads_i | input | TW | Read limit before timeout |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Last run succeeded |
| fail_o | output | 1 | Last run failed |
| cause_o | output | 2 | 0 none, 1 pulse limit, 2 low voltage, 3 timeout |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | AW | Request address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Request acknowledge |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |

## Verification
A corrupted poll state shows at the bus within one request. A skipped recheck reduces the read count by one. A lost exit write appears as a missing write before `done_o`. A wrong completion test flips pass and fail, or changes the number of reads seen before `done_o`. A miscounting timeout counter changes the read count on timeout runs, so every scenario compares the exact number of reads and writes as well as the outcome and cause. Stability of the request while waiting for acknowledge is checked with variable acknowledge latency on every transaction.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned DONE_BIT  = 7;
  localparam int unsigned PULSE_BIT = 5;
  localparam int unsigned VOLT_BIT  = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PULSE = 2'd1,
    CAUSE_VOLT  = 2'd2,
    CAUSE_TMO   = 2'd3
  } fail_cause_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL,
    S_POLL_W,
    S_RECHK,
    S_RECHK_W,
    S_EXIT,
    S_EXIT_W,
    S_DONE
  } poll_state_e;
endpackage

// File: rtl/flash_poll_bus.sv
module flash_poll_bus #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          issue_we_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic [DW-1:0] issue_wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o       <= 1'b0;
      we_o        <= 1'b0;
      addr_o      <= '0;
      wdata_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= req_o & ack_i;
      if (req_o && ack_i) begin
        req_o <= 1'b0;
        if (!we_o) rsp_data_o <= rdata_i;
      end else if (issue_i && !req_o) begin
        req_o   <= 1'b1;
        we_o    <= issue_we_i;
        addr_o  <= issue_addr_i;
        wdata_o <= issue_wdata_i;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)); // R3
  AST_RSP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_o && ack_i)); // R3
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_poll_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          flag_mode_i,
  input  logic          exp_d7_i,
  input  logic [DW-1:0] status_i,
  output logic          complete_o,
  output logic          err_pulse_o,
  output logic          err_volt_o
);
  logic d7;
  logic unused_status;

  assign d7            = status_i[DONE_BIT];
  assign unused_status = ^status_i;

  generate
    if (DW > DONE_BIT) begin : g_ok
      always_comb begin
        complete_o  = flag_mode_i ? d7 : (d7 == exp_d7_i);
        err_pulse_o = status_i[PULSE_BIT];
        err_volt_o  = status_i[VOLT_BIT];
      end
    end
  endgenerate

  initial assert (DW > DONE_BIT);
endmodule

// File: rtl/flash_poll_tmo.sv
module flash_poll_tmo #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] limit_i,
  input  logic          inc_i,
  output logic          last_o
);
  localparam int unsigned CW = TW + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;
  logic [CW-1:0] eff_lim;
  logic [CW-1:0] next_cnt;

  assign eff_lim  = (lim_q == '0) ? CW'(1) : {1'b0, lim_q};
  assign next_cnt = {1'b0, cnt_q} + CW'(1);
  assign last_o   = next_cnt >= eff_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (inc_i && !last_o) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < eff_lim); // R9
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   TW        = 8,
  parameter logic [AW-1:0] EXIT_ADDR = AW'(16'h0555),
  parameter logic [DW-1:0] EXIT_DATA = DW'(8'hF0)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] poll_addr_i,
  input  logic          exp_d7_i,
  input  logic [TW-1:0] max_reads_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [1:0]    cause_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  poll_state_e state_q, state_d;

  logic          flag_mode_q;
  logic          exp_d7_q;
  logic [AW-1:0] addr_q;
  logic          res_pass_q;
  fail_cause_e   cause_q;
  logic          exit_acked_q;
  logic          done_q, pass_q, fail_q;

  logic          issue, issue_we;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          complete, err_pulse, err_volt;
  logic          accept, tmo_inc, tmo_last;

  assign accept  = (state_q == S_IDLE) && start_i;
  assign tmo_inc = (state_q == S_POLL_W) && rsp_valid && !complete && !err_pulse && !err_volt;

  flash_poll_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .issue_we_i   (issue_we),
    .issue_addr_i (issue_addr),
    .issue_wdata_i(issue_wdata),
    .req_o        (bus_req_o),
    .we_o         (bus_we_o),
    .addr_o       (bus_addr_o),
    .wdata_o      (bus_wdata_o),
    .ack_i        (bus_ack_i),
    .rdata_i      (bus_rdata_i),
    .rsp_valid_o  (rsp_valid),
    .rsp_data_o   (rsp_data)
  );

  flash_poll_eval #(.DW(DW)) u_eval (
    .flag_mode_i(flag_mode_q),
    .exp_d7_i   (exp_d7_q),
    .status_i   (rsp_data),
    .complete_o (complete),
    .err_pulse_o(err_pulse),
    .err_volt_o (err_volt)
  );

  flash_poll_tmo #(.TW(TW)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .limit_i(max_reads_i),
    .inc_i  (tmo_inc),
    .last_o (tmo_last)
  );

  always_comb begin
    state_d     = state_q;
    issue       = 1'b0;
    issue_we    = 1'b0;
    issue_addr  = addr_q;
    issue_wdata = '0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_POLL;
      S_POLL: begin
        issue   = 1'b1;
        state_d = S_POLL_W;
      end
      S_POLL_W: if (rsp_valid) begin
        if (complete)                  state_d = flag_mode_q ? S_EXIT : S_DONE;
        else if (err_pulse || err_volt) state_d = S_RECHK;
        else if (tmo_last)             state_d = S_EXIT;
        else                           state_d = S_POLL;
      end
      S_RECHK: begin
        issue   = 1'b1;
        state_d = S_RECHK_W;
      end
      S_RECHK_W: if (rsp_valid) begin
        state_d = (complete && !flag_mode_q) ? S_DONE : S_EXIT;
      end
      S_EXIT: begin
        issue       = 1'b1;
        issue_we    = 1'b1;
        issue_addr  = EXIT_ADDR;
        issue_wdata = EXIT_DATA;
        state_d     = S_EXIT_W;
      end
      S_EXIT_W: if (rsp_valid) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      flag_mode_q  <= 1'b0;
      exp_d7_q     <= 1'b0;
      addr_q       <= '0;
      res_pass_q   <= 1'b0;
      cause_q      <= CAUSE_NONE;
      exit_acked_q <= 1'b0;
      done_q       <= 1'b0;
      pass_q       <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_DONE);
      if (accept) begin
        flag_mode_q  <= (mode_i == 2'b01);
        exp_d7_q     <= exp_d7_i;
        addr_q       <= poll_addr_i;
        res_pass_q   <= 1'b0;
        cause_q      <= CAUSE_NONE;
        exit_acked_q <= 1'b0;
        pass_q       <= 1'b0;
        fail_q       <= 1'b0;
      end
      if (state_q == S_POLL_W && rsp_valid) begin
        if (complete)       res_pass_q <= 1'b1;
        else if (err_pulse) cause_q    <= CAUSE_PULSE;
        else if (err_volt)  cause_q    <= CAUSE_VOLT;
        else if (tmo_last)  cause_q    <= CAUSE_TMO;
      end
      if (state_q == S_RECHK_W && rsp_valid && complete) begin
        res_pass_q <= 1'b1;
        cause_q    <= CAUSE_NONE;
      end
      if (state_q == S_EXIT_W && rsp_valid) exit_acked_q <= 1'b1;
      if (state_q == S_DONE) begin
        pass_q <= res_pass_q;
        fail_q <= !res_pass_q;
      end
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign fail_o  = fail_q;
  assign cause_o = cause_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R10
  AST_READ_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_addr_o == addr_q); // R2
  AST_EXIT_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> exit_acked_q); // R8
  AST_MODE0_PASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) && !flag_mode_q |-> !exit_acked_q); // R4
  AST_FLAG_PASS_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) && flag_mode_q |-> exit_acked_q); // R5
endmodule

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
  typedef struct packed {
    logic [1:0]  mode;
    logic        d7;
    logic [7:0]  lim;
    logic [31:0] script;  // s0 in [31:24], last entry repeats
    logic [1:0]  lat;
    logic        pass;
    logic [1:0]  cause;
    logic [7:0]  reads;
    logic [7:0]  writes;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 8'd8, 32'h00_00_80_80, 2'd0, 1'b1, 2'd0, 8'd3, 8'd0}, // R4
    '{2'b00, 1'b0, 8'd8, 32'h80_80_00_00, 2'd1, 1'b1, 2'd0, 8'd3, 8'd0}, // R4 inverted
    '{2'b01, 1'b0, 8'd8, 32'h00_80_80_80, 2'd2, 1'b1, 2'd0, 8'd2, 8'd1}, // R5
    '{2'b00, 1'b1, 8'd8, 32'h00_20_20_20, 2'd0, 1'b0, 2'd1, 8'd3, 8'd1}, // R6 fail
    '{2'b00, 1'b1, 8'd8, 32'h20_80_80_80, 2'd3, 1'b1, 2'd0, 8'd2, 8'd0}, // R6 recover
    '{2'b01, 1'b0, 8'd8, 32'h08_08_08_08, 2'd1, 1'b0, 2'd2, 8'd2, 8'd1}, // R7
    '{2'b01, 1'b0, 8'd8, 32'h28_28_28_28, 2'd0, 1'b0, 2'd1, 8'd2, 8'd1}, // R7 priority
    '{2'b00, 1'b1, 8'd3, 32'h00_00_00_00, 2'd2, 1'b0, 2'd3, 8'd3, 8'd1}, // R9
    '{2'b10, 1'b1, 8'd8, 32'h00_80_80_80, 2'd1, 1'b1, 2'd0, 8'd2, 8'd0}, // R11
    '{2'b00, 1'b1, 8'd0, 32'h00_00_00_00, 2'd0, 1'b0, 2'd3, 8'd1, 8'd1}, // R9 zero
    '{2'b01, 1'b0, 8'd8, 32'h08_80_80_80, 2'd1, 1'b1, 2'd0, 8'd2, 8'd1}  // R7 recover
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [15:0] poll_addr_i = '0;
  logic        exp_d7_i = 1'b0;
  logic [7:0]  max_reads_i = '0;
  logic        busy_o, done_o, pass_o, fail_o;
  logic [1:0]  cause_o;
  logic        bus_req_o, bus_we_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [7:0]  bus_rdata_i = '0;

  int errors = 0;
  int checks = 0;
  int nreads, nwrites, bad_addr, bad_wr, wcnt;
  logic [31:0] cur_script;
  logic [1:0]  cur_lat;
  logic [15:0] cur_addr;

  always #10 clk_i = ~clk_i;

  flash_poll_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus slave
  always @(negedge clk_i) begin
    if (bus_ack_i) begin
      bus_ack_i <= 1'b0;
    end else if (bus_req_o) begin
      if (wcnt >= int'(cur_lat)) begin
        wcnt      <= 0;
        bus_ack_i <= 1'b1;
        if (bus_we_o) begin
          nwrites <= nwrites + 1;
          if (bus_addr_o !== 16'h0555 || bus_wdata_o !== 8'hF0) bad_wr <= bad_wr + 1;
        end else begin
          if (bus_addr_o !== cur_addr) bad_addr <= bad_addr + 1;
          case (nreads)
            0:       bus_rdata_i <= cur_script[31:24];
            1:       bus_rdata_i <= cur_script[23:16];
            2:       bus_rdata_i <= cur_script[15:8];
            default: bus_rdata_i <= cur_script[7:0];
          endcase
          nreads <= nreads + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic launch(input logic [1:0] m, input logic d7, input logic [7:0] lim,
                        input logic [31:0] scr, input logic [1:0] lat, input logic [15:0] a);
    @(negedge clk_i);
    nreads = 0; nwrites = 0; bad_addr = 0; bad_wr = 0; wcnt = 0;
    cur_script = scr; cur_lat = lat; cur_addr = a;
    mode_i = m; exp_d7_i = d7; max_reads_i = lim; poll_addr_i = a;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  initial begin
    bit ok;
    cur_script = '0; cur_lat = '0; cur_addr = '0;
    nreads = 0; nwrites = 0; bad_addr = 0; bad_wr = 0; wcnt = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 pass/fail", {pass_o, fail_o}, 0);
    chk("R1 req", bus_req_o, 0);
    chk("R1 cause", cause_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      launch(VECS[v].mode, VECS[v].d7, VECS[v].lim, VECS[v].script, VECS[v].lat,
             16'h1200 + 16'(v));
      wait_done(ok);
      chk($sformatf("R10 watchdog v%0d", v), ok, 1);
      chk($sformatf("R4 R5 R6 R7 R9 pass v%0d", v), pass_o, VECS[v].pass);
      chk($sformatf("R10 fail v%0d", v), fail_o, !VECS[v].pass);
      chk($sformatf("R6 R7 R9 cause v%0d", v), cause_o, VECS[v].cause);
      chk($sformatf("R6 R9 reads v%0d", v), nreads, VECS[v].reads);
      chk($sformatf("R5 R8 writes v%0d", v), nwrites, VECS[v].writes);
      chk($sformatf("R2 read addr v%0d", v), bad_addr, 0);
      chk($sformatf("R8 exit cmd v%0d", v), bad_wr, 0);
      @(negedge clk_i);
      chk($sformatf("R10 pulse v%0d", v), done_o, 0);
      chk($sformatf("R10 hold v%0d", v), {pass_o, fail_o}, {VECS[v].pass, !VECS[v].pass});
    end

    // R10: start while busy is ignored
    launch(2'b00, 1'b1, 8'd8, 32'h00_00_00_80, 2'd2, 16'h0042);
    repeat (3) @(negedge clk_i);
    chk("R10 busy", busy_o, 1);
    mode_i = 2'b01; poll_addr_i = 16'h7777; exp_d7_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(ok);
    chk("R10 ignored start done", ok, 1);
    chk("R10 ignored start pass", pass_o, 1);
    chk("R10 ignored start reads", nreads, 4);
    chk("R10 ignored start writes", nwrites, 0);
    chk("R2 ignored start addr", bad_addr, 0);

    // R3 long acknowledge latency with a mid-run reset
    launch(2'b01, 1'b0, 8'd8, 32'h00_00_00_00, 2'd3, 16'h0100);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset mid-run req", bus_req_o, 0);
    chk("R1 reset mid-run busy", busy_o, 0);
    chk("R1 reset mid-run result", {pass_o, fail_o, cause_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule